// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a polled SPI master. Software drives it through four 32-bit registers on a simple single-cycle bus: control, status, data and baud. It queues outgoing words in a transmit FIFO. The shifter then moves each word out MSB first on MOSI and collects one word from MISO for each word it sends. The collected words wait in a receive FIFO until software reads the data register. Each direction holds 16 bytes, so the number of words a FIFO holds depends on the selected word width of 8, 16 or 32 bits.

The clock polarity, the SCK edge that launches output data and the point where MISO is sampled can each be set in the control register. The serial clock rate comes from a 9-bit divider. On request the block drives its own active-low slave select, which stays asserted while words are queued or shifting. Every register has a raw, a set and a clear write alias, so single bits can be changed without a read-modify-write.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control, status and baud read 0, `ss_n` is 1 and `sck` is 0.
- R2: The bus address is {register[3:2], alias[1:0]}. The registers are control=0, status=1, data=2 and baud=3. The aliases are raw=0 (also 3), clear=1 (clears the 1 bits written) and set=2 (ORs in the 1 bits written). Only control bits 5, 6, 8, 9, 11:10, 15, 16 and 28 are storable, so bit 31 always reads 0. Baud keeps 9 bits.
- R3: Control bits 11:10 select the word width: 0=8, 1=16, any other value=32 bits. With bit 16 set, each FIFO holds 16, 8 or 4 words for those widths. With bit 16 clear, each FIFO holds 1 word. A data write to a full transmit FIFO is ignored. Status bits 20:16 give the transmit fill level and bits 28:24 the receive fill level.
- R4: Each word written to the data register (raw alias) is shifted out MSB first. Exactly one received word, zero-extended to the width, is queued for it. Reading the data register pops that queue.
- R5: SCK rests at control bit 6. A word takes 2×width SCK edges, spaced baud+1 clock cycles apart, and SCK ends at its rest level.
- R6: With control bit 8 set, MOSI changes only on active-to-idle SCK edges. With it clear, MOSI changes on idle-to-active edges. With control bit 9 set, MISO is sampled at the end of each bit's output time rather than at its middle. In all four combinations, a word looped back from MOSI to MISO is returned unchanged.
- R7: With control bit 28 set, `ss_n` is 0 while the transmit FIFO is non-empty or a word is shifting, and 1 otherwise. With bit 28 clear, `ss_n` stays 1.
- R8: If a word completes while the receive FIFO is full, the word is dropped and status bit 6 is set. Only a clear-alias write with bit 6 set removes the flag.
- R9: While control bit 15 (enable) is 0, both FIFOs are empty, the shifter is reset and SCK rests at its idle level. Data writes are ignored, and the overflow flag is kept.
- R10: Reading the data register while the receive FIFO is empty returns 0.
- R11: Words shift only while control bits 15 and 5 are both 1. With bit 5 clear, queued words stay in the transmit FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | {register, alias} |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive FIFO on data register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench uses the default 16-byte buffer and the 32-bit bus. This makes all three FIFO capacities (16, 8 and 4 words) reachable by filling the FIFO while the shifter is held off. MISO is looped back from MOSI, so every combination of polarity, launch edge and sample point can be checked by data integrity together with SCK edge counts. Small baud values keep the transfers short, so overflow is reached within a few hundred cycles. A larger baud value exposes the half-period spacing and leaves room to disable the block in the middle of a word.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_BAUD = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        AL_RAW  = 2'd0,
        AL_CLR  = 2'd1,
        AL_SET  = 2'd2,
        AL_RAW2 = 2'd3
    } alias_e;

    localparam int B_MASTER = 5;
    localparam int B_CKP    = 6;
    localparam int B_CKE    = 8;
    localparam int B_SMP    = 9;
    localparam int B_WID    = 10;
    localparam int B_EN     = 15;
    localparam int B_FEN    = 16;
    localparam int B_SSEN   = 28;
    localparam int B_OVF    = 6;

    localparam logic [31:0] CTRL_MASK = 32'h1001_8F60;

    typedef struct packed {
        logic       ssen;
        logic       fen;
        logic       en;
        logic [1:0] wid;
        logic       smp;
        logic       cke;
        logic       ckp;
        logic       master;
    } ctrl_s;

    function automatic logic [31:0] apply_alias(input logic [1:0] al,
                                                input logic [31:0] cur,
                                                input logic [31:0] wd);
        case (al)
            AL_CLR:  return cur & ~wd;
            AL_SET:  return cur | wd;
            default: return wd;
        endcase
    endfunction

    function automatic logic [5:0] word_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd8;
            2'd1:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [31:0] word_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic ctrl_s unpack_ctrl(input logic [31:0] r);
        ctrl_s c;
        c.ssen   = r[B_SSEN];
        c.fen    = r[B_FEN];
        c.en     = r[B_EN];
        c.wid    = r[B_WID +: 2];
        c.smp    = r[B_SMP];
        c.cke    = r[B_CKE];
        c.ckp    = r[B_CKP];
        c.master = r[B_MASTER];
        return c;
    endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [LW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level >= cap);
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    a_r3_full_push_ignored: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> (level == $past(level)));

    a_r3_level_bounded: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ckp,
    input  logic             cke,
    input  logic             smp,
    input  logic [5:0]       nbits,
    input  logic [DIV_W-1:0] baud,
    input  logic             tx_valid,
    input  logic [31:0]      tx_word,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [31:0]      rx_word,
    output logic             busy,
    output logic             sck,
    output logic             mosi
);
    logic [DIV_W-1:0] div_cnt;
    logic [6:0]       edge_cnt, e_next, last_e;
    logic [31:0]      tsr, rsr;
    logic             phase, tick, sample_now, shift_now;
    logic [1:0]       ofs;

    assign tick   = busy && (div_cnt == baud);
    assign e_next = edge_cnt + 7'd1;
    assign last_e = {nbits, 1'b0};
    assign ofs    = {1'b0, ~cke} + {1'b0, smp};

    always_comb begin
        sample_now = tick &&
            (((e_next >= 7'(ofs) + 7'd1) && (e_next[0] != ofs[0]) && (e_next < last_e + 7'd1)) ||
             ((ofs == 2'd2) && (e_next == last_e)));
        if (cke) shift_now = tick && !e_next[0] && (e_next < last_e);
        else     shift_now = tick && e_next[0] && (e_next >= 7'd3);
    end

    assign tx_pop  = run && !busy && tx_valid;
    assign rx_push = tick && (e_next == last_e);
    assign rx_word = sample_now ? {rsr[30:0], miso} : rsr;
    assign sck     = busy ? (ckp ^ phase) : ckp;
    assign mosi    = tsr[31];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy     <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            phase    <= 1'b0;
            tsr      <= '0;
            rsr      <= '0;
        end else if (!busy) begin
            if (tx_valid) begin
                busy     <= 1'b1;
                tsr      <= tx_word << (6'd32 - nbits);
                rsr      <= '0;
                div_cnt  <= '0;
                edge_cnt <= '0;
                phase    <= 1'b0;
            end
        end else begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) begin
                edge_cnt <= e_next;
                phase    <= ~phase;
                if (e_next == last_e) busy <= 1'b0;
            end
            if (sample_now) rsr <= {rsr[30:0], miso};
            if (shift_now)  tsr <= tsr << 1;
        end
    end

    // R6: with CKE set, a leading (idle-to-active) edge never moves MOSI
    a_r6_lead_edge_hold: assert property (@(posedge clk) disable iff (rst)
        (run && busy && cke && tick && e_next[0]) |=> $stable(mosi));

    // R5: a completed word leaves SCK at its rest level
    a_r5_sck_rests: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> (sck == $past(ckp)));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int BUF_BYTES = 16,
    parameter int DIV_W     = 9,
    localparam int LW       = $clog2(BUF_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        ss_n
);
    logic [31:0]      ctrl_q;
    logic [DIV_W-1:0] baud_q;
    logic             ovf_q;
    ctrl_s            c;
    logic [1:0]       reg_sel, alias_sel;
    logic [LW-1:0]    cap, tx_lvl, rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [31:0]      tx_head, rx_head, eng_rx;
    logic             tx_pop, eng_push, eng_busy, run, stat_clr;
    logic [5:0]       nbits;

    assign reg_sel   = bus_addr[3:2];
    assign alias_sel = bus_addr[1:0];
    assign c         = unpack_ctrl(ctrl_q);
    assign nbits     = word_bits(c.wid);
    assign run       = c.en && c.master;
    assign cap       = c.fen ? LW'(BUF_BYTES / (nbits / 8)) : LW'(1);
    assign stat_clr  = bus_wr && (reg_sel == REG_STAT) && (alias_sel == AL_CLR) && bus_wdata[B_OVF];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            baud_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (bus_wr && reg_sel == REG_CTRL)
                ctrl_q <= apply_alias(alias_sel, ctrl_q, bus_wdata) & CTRL_MASK;
            if (bus_wr && reg_sel == REG_BAUD)
                baud_q <= DIV_W'(apply_alias(alias_sel, 32'(baud_q), bus_wdata));
            if (eng_push && rx_full) ovf_q <= 1'b1;
            else if (stat_clr)       ovf_q <= 1'b0;
        end
    end

    spi_word_fifo #(.DEPTH(BUF_BYTES), .W(32)) u_txq (
        .clk(clk), .rst(rst), .clr(!c.en), .cap(cap),
        .push(bus_wr && reg_sel == REG_DATA && (alias_sel == AL_RAW || alias_sel == AL_RAW2)),
        .din(bus_wdata), .pop(tx_pop), .dout(tx_head),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    spi_word_fifo #(.DEPTH(BUF_BYTES), .W(32)) u_rxq (
        .clk(clk), .rst(rst), .clr(!c.en), .cap(cap),
        .push(eng_push), .din(eng_rx & word_mask(c.wid)),
        .pop(bus_rd && reg_sel == REG_DATA), .dout(rx_head),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst(rst), .run(run), .ckp(c.ckp), .cke(c.cke), .smp(c.smp),
        .nbits(nbits), .baud(baud_q), .tx_valid(!tx_empty), .tx_word(tx_head),
        .miso(miso), .tx_pop(tx_pop), .rx_push(eng_push), .rx_word(eng_rx),
        .busy(eng_busy), .sck(sck), .mosi(mosi)
    );

    assign ss_n = !(c.ssen && (!tx_empty || eng_busy));

    always_comb begin
        bus_rdata = '0;
        case (reg_sel)
            REG_CTRL: bus_rdata = ctrl_q;
            REG_STAT: begin
                bus_rdata[B_OVF]     = ovf_q;
                bus_rdata[16 +: LW]  = tx_lvl;
                bus_rdata[24 +: LW]  = rx_lvl;
            end
            REG_DATA: bus_rdata = rx_head;
            default:  bus_rdata = 32'(baud_q);
        endcase
    end

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !stat_clr) |=> ovf_q);

    a_r9_flush_on_disable: assert property (@(posedge clk) disable iff (rst)
        !c.en |=> (tx_lvl == '0 && rx_lvl == '0));

    a_r7_select_while_shifting: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && c.ssen) |-> !ss_n);

    a_r11_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |=> !eng_busy);

endmodule

// File: tb/spi_fifo_master_test.sv
`timescale 1ns/1ps
module spi_fifo_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        sck, mosi, ss_n;

    int checks = 0, errors = 0;
    int cyc = 0, last_t = 0, gap = 0, edges = 0;
    logic sck_q = 1'b0;

    localparam logic [31:0] EN = 32'h1 << 15, MST = 32'h1 << 5, CKP = 32'h1 << 6,
                            CKE = 32'h1 << 8, SMP = 32'h1 << 9, FEN = 32'h1 << 16,
                            SSEN = 32'h1 << 28;
    localparam logic [3:0] A_CTRL = 4'h0, A_CTRL_C = 4'h1, A_CTRL_S = 4'h2,
                           A_STAT = 4'h4, A_STAT_C = 4'h5, A_DATA = 4'h8,
                           A_BAUD = 4'hC, A_BAUD_C = 4'hD;

    // {wid[1:0], ckp, cke, smp, data[31:0]}
    localparam int NV = 8;
    localparam logic [36:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b1, 1'b0, 32'h0000_00A5},
        {2'd0, 1'b1, 1'b0, 1'b1, 32'h0000_003C},
        {2'd1, 1'b0, 1'b0, 1'b0, 32'h0000_BEEF},
        {2'd1, 1'b1, 1'b1, 1'b1, 32'hFFFF_1234},
        {2'd2, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF},
        {2'd2, 1'b1, 1'b1, 1'b0, 32'h8000_0001},
        {2'd0, 1'b0, 1'b1, 1'b1, 32'h0000_0181},
        {2'd1, 1'b1, 1'b0, 1'b0, 32'h0000_8001}
    };

    spi_fifo_master uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
        .miso(mosi), .ss_n(ss_n)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (sck !== sck_q) begin
            gap    <= cyc - last_t;
            last_t <= cyc;
            edges  <= edges + 1;
        end
        sck_q <= sck;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rx(input int lvl);
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(A_STAT, s);
            if (int'((s >> 24) & 31) >= lvl) return;
        end
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, s;
        int e0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_BAUD, v); check("R1 baud", v, 0);
        check("R1 ss_n", 32'(ss_n), 1);
        check("R1 sck", 32'(sck), 0);

        // R2 aliases and masks
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R2 ctrl raw mask", v, 32'h1001_8F60);
        wr(A_CTRL_C, EN);          rd(A_CTRL, v); check("R2 ctrl clear", v, 32'h1001_0F60);
        wr(A_CTRL_S, EN);          rd(A_CTRL, v); check("R2 ctrl set", v, 32'h1001_8F60);
        wr(A_CTRL, 0);
        wr(A_BAUD, 32'h3FF);       rd(A_BAUD, v); check("R2 baud 9 bits", v, 32'h1FF);
        wr(A_BAUD_C, 32'h0F0);     rd(A_BAUD, v); check("R2 baud clear", v, 32'h10F);

        // R4/R5/R6 table of modes with loopback
        wr(A_BAUD, 1);
        for (int i = 0; i < NV; i++) begin
            logic [1:0] w;
            logic [31:0] exp;
            w = VEC[i][36:35];
            wr(A_CTRL, EN | MST | FEN | (32'(w) << 10) | (VEC[i][34] ? CKP : 0) |
                       (VEC[i][33] ? CKE : 0) | (VEC[i][32] ? SMP : 0));
            idle(2);
            e0 = edges;
            wr(A_DATA, VEC[i][31:0]);
            wait_rx(1);
            idle(4);
            exp = (w == 0) ? (VEC[i][31:0] & 32'hFF) : (w == 1) ? (VEC[i][31:0] & 32'hFFFF) : VEC[i][31:0];
            rd(A_DATA, v); check($sformatf("R4 R6 loopback vec %0d", i), v, exp);
            check($sformatf("R5 edge count vec %0d", i), 32'(edges - e0), (w == 0) ? 16 : (w == 1) ? 32 : 64);
            check($sformatf("R5 sck rest vec %0d", i), 32'(sck), 32'(VEC[i][34]));
        end

        // R5 half-period spacing
        wr(A_BAUD, 3);
        wr(A_CTRL, EN | MST | FEN);
        wr(A_DATA, 32'h5A);
        wait_rx(1); idle(4);
        check("R5 half period", 32'(gap), 4);
        rd(A_DATA, v);

        // R10 empty read
        rd(A_DATA, v); check("R10 empty read", v, 0);

        // R3/R11 capacities with shifting held off
        wr(A_CTRL, EN | FEN);
        for (int i = 0; i < 17; i++) wr(A_DATA, i);
        rd(A_STAT, s); check("R3 R11 cap 8-bit", (s >> 16) & 31, 16);
        wr(A_CTRL, 0); wr(A_CTRL, EN | FEN | (32'd1 << 10));
        for (int i = 0; i < 9; i++) wr(A_DATA, i);
        rd(A_STAT, s); check("R3 cap 16-bit", (s >> 16) & 31, 8);
        wr(A_CTRL, 0); wr(A_CTRL, EN | FEN | (32'd2 << 10));
        for (int i = 0; i < 5; i++) wr(A_DATA, i);
        rd(A_STAT, s); check("R3 cap 32-bit", (s >> 16) & 31, 4);
        wr(A_CTRL, 0); wr(A_CTRL, EN);
        for (int i = 0; i < 3; i++) wr(A_DATA, i);
        rd(A_STAT, s); check("R3 single-entry", (s >> 16) & 31, 1);
        wr(A_CTRL, MST | FEN);
        wr(A_DATA, 32'h77);
        rd(A_STAT, s); check("R9 write ignored while disabled", (s >> 16) & 31, 0);

        // R7 slave select
        wr(A_BAUD, 1);
        wr(A_CTRL, EN | FEN | SSEN);
        check("R7 ss idle", 32'(ss_n), 1);
        wr(A_DATA, 32'hC3);
        check("R7 ss queued", 32'(ss_n), 0);
        wr(A_CTRL_S, MST);
        wait_rx(1); idle(4);
        check("R7 ss released", 32'(ss_n), 1);
        rd(A_DATA, v); check("R4 ss word", v, 32'hC3);
        wr(A_CTRL_C, SSEN);
        wr(A_DATA, 32'h11);
        idle(3);
        check("R7 ss disabled", 32'(ss_n), 1);
        wait_rx(1); rd(A_DATA, v);

        // R8 overflow
        wr(A_BAUD, 0);
        wr(A_CTRL, EN | MST | FEN | (32'd2 << 10));
        for (int i = 0; i < 5; i++) begin
            wr(A_DATA, 32'h1000_0000 + i);
            idle(100);
        end
        rd(A_STAT, s);
        check("R8 ovf set", (s >> 6) & 1, 1);
        check("R8 rx level", (s >> 24) & 31, 4);
        rd(A_DATA, v); check("R8 first word kept", v, 32'h1000_0000);
        rd(A_DATA, v); rd(A_DATA, v);
        rd(A_DATA, v); check("R8 fourth word kept", v, 32'h1000_0003);
        rd(A_DATA, v); check("R8 fifth dropped", v, 0);
        wr(A_STAT, 0);
        rd(A_STAT, s); check("R8 raw write no clear", (s >> 6) & 1, 1);

        // R9 disable mid-word
        wr(A_BAUD, 7);
        wr(A_CTRL, EN | MST | FEN | CKP | (32'd2 << 10));
        wr(A_DATA, 32'hAAAA_5555);
        wr(A_DATA, 32'h1234_5678);
        idle(40);
        wr(A_CTRL_C, EN);
        idle(2);
        check("R9 sck idle", 32'(sck), 1);
        rd(A_STAT, s);
        check("R9 tx flushed", (s >> 16) & 31, 0);
        check("R9 rx flushed", (s >> 24) & 31, 0);
        check("R9 ovf kept", (s >> 6) & 1, 1);
        wr(A_STAT_C, 32'h40);
        rd(A_STAT, s); check("R8 clear alias", (s >> 6) & 1, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule